// File: doc/BRIEF.md
# Indexed Draw Vertex Cache

This block sits between a vertex index source and a vertex processing unit. For each vertex of a draw it works out the vertex index. In indexed draws it searches a small fully associative store of recently processed vertices. On a hit it hands back the stored result without running the processing unit. On a miss it sends the index to the processing unit, waits for the result, forwards it, and keeps a copy.

A draw is launched with a one-cycle `start` pulse. The pulse carries the mode, the element width of the index array, the vertex count and a start offset. In indexed mode the indexes arrive over a valid/ready stream, one array element per vertex. In non-indexed mode each index is the vertex position plus the offset, and the cache is bypassed completely. Results leave in vertex order over a valid/ready port, together with the index and a hit flag. A `done` level rises after the last result has been accepted.

The store has one entry per slot, and each entry holds an index tag and a processed-vertex payload. New results fill slots in strict rotation. Every draw start wipes all tags, so nothing carries over from one draw to the next. The all-ones index is reserved as the empty-tag value. An index equal to it is reported and never cached.

Top module: `vtx_index_cache`

## Requirements
- R1: After reset, `out_valid`, `idx_ready`, `proc_req_valid`, `done` and `bad_index` are all low.
- R2: In indexed mode, an index that matches a tag filled earlier in the same draw produces an output with `out_hit`=1 and the payload stored with that tag, and issues no processing request.
- R3: An index that does not hit is presented on `proc_req_index` with `proc_req_valid`. The payload accepted from `proc_rsp_data` is forwarded with `out_hit`=0, and in indexed mode it is stored together with the index.
- R4: Fills go to slots 0, 1, … DEPTH-1 and then wrap to 0, one step per fill, with the pointer returning to slot 0 at each draw start. So after DEPTH+1 distinct indexes, the first one misses again.
- R5: A draw start invalidates every tag, so no index hits on a result from an earlier draw.
- R6: The format bit `cfg_wide`=1 takes the full 16-bit element from `idx_data`. With `cfg_wide`=0 only `idx_data[7:0]` is used, zero-extended, and the upper byte is ignored.
- R7: With `cfg_indexed`=0, the index of vertex k is (k + `cfg_offset`) mod 2^16. `idx_ready` stays low, every vertex takes the miss path, and nothing is stored.
- R8: An index of all ones (0xFFFF) raises `bad_index` for exactly one cycle. It goes down the miss path and is never stored, so it never hits.
- R9: Exactly `cfg_count` outputs appear, in vertex order. While `out_valid` is high and `out_ready` is low, `out_data`, `out_index` and `out_hit` hold steady.
- R10: `done` is low while a draw runs. It is high from the cycle after the last output is accepted until the next start. A count of zero gives `done` with no output.
- R11: A `start` pulse while a draw is in progress is ignored, and the running draw completes with its own settings.
- R12: A processing request holds its index until accepted. At most one request is outstanding, and no request is raised while an output is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a draw; honoured only when idle or done |
| cfg_indexed | input | 1 | 1 = indexes from stream with caching, 0 = position + offset |
| cfg_wide | input | 1 | 1 = 16-bit index elements, 0 = 8-bit |
| cfg_count | input | CNT_W | Number of vertices in the draw |
| cfg_offset | input | IDX_W | Start offset for non-indexed draws |
| idx_valid | input | 1 | Index element available |
| idx_ready | output | 1 | Index element accepted this cycle |
| idx_data | input | IDX_W | Raw index array element |
| proc_req_valid | output | 1 | Processing request pending |
| proc_req_ready | input | 1 | Processing unit accepts request |
| proc_req_index | output | IDX_W | Index to process |
| proc_rsp_valid | input | 1 | Processed vertex available |
| proc_rsp_ready | output | 1 | Block accepts processed vertex |
| proc_rsp_data | input | PAY_W | Processed vertex payload |
| out_valid | output | 1 | Output vertex pending |
| out_ready | input | 1 | Consumer accepts output |
| out_data | output | PAY_W | Processed vertex payload |
| out_index | output | IDX_W | Index of the output vertex |
| out_hit | output | 1 | Output came from the cache |
| done | output | 1 | Draw finished |
| bad_index | output | 1 | One-cycle flag for an all-ones index |

## Verification
A corrupted tag or a wrong priority choice shows up as a wrong `out_hit` or a payload carrying the serial number of the wrong fill. This appears on the very output for the repeated index, because each response payload encodes a unique request serial. A replacement pointer that drifts stays invisible until the store wraps. It surfaces on the first index after DEPTH+1 distinct fills, as a hit where a miss is expected or the reverse. A control state that goes astray shows within a cycle or two. The possible symptoms are an unstable output under backpressure, two handshakes in flight together, or `done` rising with results still owed.

// File: rtl/vc_pkg.sv
package vc_pkg;

    localparam int VC_DEPTH_DEF = 32;
    localparam int VC_IDX_W_DEF = 16;
    localparam int VC_PAY_W_DEF = 32;
    localparam int VC_CNT_W_DEF = 16;
    localparam int VC_NARROW_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOOKUP,
        ST_REQ,
        ST_WAIT,
        ST_EMIT,
        ST_DONE
    } vc_state_e;

    typedef struct packed {
        logic indexed;
        logic wide;
    } vc_mode_t;

    function automatic logic state_accepts_start(vc_state_e s);
        return (s == ST_IDLE) || (s == ST_DONE);
    endfunction

endpackage

// File: rtl/vc_tag_store.sv
module vc_tag_store
    import vc_pkg::*;
#(
    parameter int DEPTH = VC_DEPTH_DEF,
    parameter int IDX_W = VC_IDX_W_DEF,
    parameter int PAY_W = VC_PAY_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [IDX_W-1:0] lookup_idx,
    output logic             hit,
    output logic [DEPTH-1:0] hit_vec,
    output logic [PAY_W-1:0] hit_data,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [PAY_W-1:0] fill_data
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    logic [IDX_W-1:0] tag_q [DEPTH];
    logic [PAY_W-1:0] pay_q [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] sel;
    logic             lookup_legal;

    assign lookup_legal = (lookup_idx != {IDX_W{1'b1}});

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic slot_sel;
        assign slot_sel   = fill_en && (ptr_q == PTR_W'(e));
        assign hit_vec[e] = lookup_legal && (tag_q[e] == lookup_idx);

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                tag_q[e] <= {IDX_W{1'b1}};
            end else if (slot_sel) begin
                tag_q[e] <= fill_idx;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                pay_q[e] <= '0;
            end else if (slot_sel) begin
                pay_q[e] <= fill_data;
            end
        end
    end

    // lowest-numbered matching slot wins
    always_comb begin
        sel = '0;
        for (int e = DEPTH - 1; e >= 0; e--) begin
            if (hit_vec[e]) begin
                sel = PTR_W'(e);
            end
        end
    end

    assign hit      = |hit_vec;
    assign hit_data = pay_q[sel];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ptr_q <= '0;
        end else if (fill_en) begin
            ptr_q <= (ptr_q == LAST_SLOT) ? '0 : ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/vc_index_src.sv
module vc_index_src
    import vc_pkg::*;
#(
    parameter int IDX_W = VC_IDX_W_DEF,
    parameter int CNT_W = VC_CNT_W_DEF
) (
    input  vc_mode_t         mode,
    input  logic [CNT_W-1:0] pos,
    input  logic [IDX_W-1:0] offset,
    input  logic [IDX_W-1:0] raw,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] from_array;
    logic [IDX_W-1:0] from_count;

    assign from_array = mode.wide ? raw : IDX_W'(raw[VC_NARROW_W-1:0]);
    assign from_count = IDX_W'(pos) + offset;
    assign idx        = mode.indexed ? from_array : from_count;

endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
    import vc_pkg::*;
#(
    parameter int IDX_W = VC_IDX_W_DEF,
    parameter int PAY_W = VC_PAY_W_DEF,
    parameter int CNT_W = VC_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cfg_indexed,
    input  logic             cfg_wide,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [IDX_W-1:0] cfg_offset,
    input  logic             idx_valid,
    output logic             idx_ready,
    input  logic [IDX_W-1:0] src_idx,
    output vc_mode_t         mode,
    output logic [CNT_W-1:0] pos,
    output logic [IDX_W-1:0] offset,
    output logic [IDX_W-1:0] cur_index,
    input  logic             lookup_hit,
    input  logic [PAY_W-1:0] lookup_data,
    output logic             store_clear,
    output logic             fill_en,
    output logic             proc_req_valid,
    input  logic             proc_req_ready,
    input  logic             proc_rsp_valid,
    output logic             proc_rsp_ready,
    input  logic [PAY_W-1:0] proc_rsp_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PAY_W-1:0] out_data,
    output logic             out_hit,
    output logic             done,
    output logic             bad_index
);

    vc_state_e        state_q;
    logic [CNT_W-1:0] count_q;
    logic             cur_bad;
    logic             last_vtx;
    logic             take_start;

    assign cur_bad     = (cur_index == {IDX_W{1'b1}});
    assign last_vtx    = (pos == count_q - 1'b1);
    assign take_start  = start && state_accepts_start(state_q);
    assign store_clear = take_start;

    assign idx_ready      = (state_q == ST_FETCH) && mode.indexed;
    assign proc_req_valid = (state_q == ST_REQ);
    assign proc_rsp_ready = (state_q == ST_WAIT);
    assign out_valid      = (state_q == ST_EMIT);
    assign done           = (state_q == ST_DONE);
    assign bad_index      = (state_q == ST_LOOKUP) && cur_bad;
    assign fill_en        = (state_q == ST_WAIT) && proc_rsp_valid
                            && mode.indexed && !cur_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            mode      <= '0;
            count_q   <= '0;
            offset    <= '0;
            pos       <= '0;
            cur_index <= '0;
            out_data  <= '0;
            out_hit   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (take_start) begin
                        mode.indexed <= cfg_indexed;
                        mode.wide    <= cfg_wide;
                        count_q      <= cfg_count;
                        offset       <= cfg_offset;
                        pos          <= '0;
                        state_q      <= (cfg_count == '0) ? ST_DONE : ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (!mode.indexed || idx_valid) begin
                        cur_index <= src_idx;
                        state_q   <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (mode.indexed && lookup_hit) begin
                        out_data <= lookup_data;
                        out_hit  <= 1'b1;
                        state_q  <= ST_EMIT;
                    end else begin
                        state_q  <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (proc_req_ready) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (proc_rsp_valid) begin
                        out_data <= proc_rsp_data;
                        out_hit  <= 1'b0;
                        state_q  <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        if (last_vtx) begin
                            state_q <= ST_DONE;
                        end else begin
                            pos     <= pos + 1'b1;
                            state_q <= ST_FETCH;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vtx_index_cache.sv
module vtx_index_cache
    import vc_pkg::*;
#(
    parameter int DEPTH = VC_DEPTH_DEF,
    parameter int IDX_W = VC_IDX_W_DEF,
    parameter int PAY_W = VC_PAY_W_DEF,
    parameter int CNT_W = VC_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cfg_indexed,
    input  logic             cfg_wide,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [IDX_W-1:0] cfg_offset,
    input  logic             idx_valid,
    output logic             idx_ready,
    input  logic [IDX_W-1:0] idx_data,
    output logic             proc_req_valid,
    input  logic             proc_req_ready,
    output logic [IDX_W-1:0] proc_req_index,
    input  logic             proc_rsp_valid,
    output logic             proc_rsp_ready,
    input  logic [PAY_W-1:0] proc_rsp_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PAY_W-1:0] out_data,
    output logic [IDX_W-1:0] out_index,
    output logic             out_hit,
    output logic             done,
    output logic             bad_index
);

    vc_mode_t         mode;
    logic [CNT_W-1:0] pos;
    logic [IDX_W-1:0] offset;
    logic [IDX_W-1:0] src_idx;
    logic [IDX_W-1:0] cur_index;
    logic             lookup_hit;
    logic [DEPTH-1:0] hit_vec;
    logic [PAY_W-1:0] lookup_data;
    logic             store_clear;
    logic             fill_en;

    vc_index_src #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_src (
        .mode   (mode),
        .pos    (pos),
        .offset (offset),
        .raw    (idx_data),
        .idx    (src_idx)
    );

    vc_ctrl #(.IDX_W(IDX_W), .PAY_W(PAY_W), .CNT_W(CNT_W)) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .cfg_indexed    (cfg_indexed),
        .cfg_wide       (cfg_wide),
        .cfg_count      (cfg_count),
        .cfg_offset     (cfg_offset),
        .idx_valid      (idx_valid),
        .idx_ready      (idx_ready),
        .src_idx        (src_idx),
        .mode           (mode),
        .pos            (pos),
        .offset         (offset),
        .cur_index      (cur_index),
        .lookup_hit     (lookup_hit),
        .lookup_data    (lookup_data),
        .store_clear    (store_clear),
        .fill_en        (fill_en),
        .proc_req_valid (proc_req_valid),
        .proc_req_ready (proc_req_ready),
        .proc_rsp_valid (proc_rsp_valid),
        .proc_rsp_ready (proc_rsp_ready),
        .proc_rsp_data  (proc_rsp_data),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .out_data       (out_data),
        .out_hit        (out_hit),
        .done           (done),
        .bad_index      (bad_index)
    );

    vc_tag_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PAY_W(PAY_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .clear      (store_clear),
        .lookup_idx (cur_index),
        .hit        (lookup_hit),
        .hit_vec    (hit_vec),
        .hit_data   (lookup_data),
        .fill_en    (fill_en),
        .fill_idx   (cur_index),
        .fill_data  (proc_rsp_data)
    );

    assign proc_req_index = cur_index;
    assign out_index      = cur_index;

endmodule

// File: rtl/vtx_index_cache_chk.sv
module vtx_index_cache_chk
    import vc_pkg::*;
#(
    parameter int DEPTH = VC_DEPTH_DEF,
    parameter int IDX_W = VC_IDX_W_DEF,
    parameter int PAY_W = VC_PAY_W_DEF
) (
    input logic             clk,
    input logic             rst,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PAY_W-1:0] out_data,
    input logic [IDX_W-1:0] out_index,
    input logic             out_hit,
    input logic             proc_req_valid,
    input logic             proc_req_ready,
    input logic [IDX_W-1:0] proc_req_index,
    input logic             idx_ready,
    input logic             done,
    input logic             bad_index,
    input logic [DEPTH-1:0] hit_vec,
    input vc_mode_t         mode
);

    // R1: sync reset clears every handshake and status output
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!out_valid && !idx_ready && !proc_req_valid && !done && !bad_index));

    // R9: output held under backpressure
    a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_index) && $stable(out_hit)));

    // R12: request held until accepted
    a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
        (proc_req_valid && !proc_req_ready) |=> (proc_req_valid && $stable(proc_req_index)));

    // R12: no request while an output is pending
    a_r12_single_flight: assert property (@(posedge clk) disable iff (rst)
        !(proc_req_valid && out_valid));

    // R7: bypass mode never reports a hit
    a_r7_no_hit_bypass: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !mode.indexed) |-> !out_hit);

    // R2: distinct tags, at most one slot matches
    a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R8: illegal-index flag is a single-cycle pulse
    a_r8_bad_pulse: assert property (@(posedge clk) disable iff (rst)
        bad_index |=> !bad_index);

    // R10: finished draw is silent
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!out_valid && !proc_req_valid && !idx_ready));

endmodule

bind vtx_index_cache vtx_index_cache_chk #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .PAY_W(PAY_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_data       (out_data),
    .out_index      (out_index),
    .out_hit        (out_hit),
    .proc_req_valid (proc_req_valid),
    .proc_req_ready (proc_req_ready),
    .proc_req_index (proc_req_index),
    .idx_ready      (idx_ready),
    .done           (done),
    .bad_index      (bad_index),
    .hit_vec        (hit_vec),
    .mode           (mode)
);

// File: tb/vtx_index_cache_test.sv
`timescale 1ns/1ps
module vtx_index_cache_test;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cfg_indexed = 1'b0;
    logic        cfg_wide = 1'b0;
    logic [15:0] cfg_count = '0;
    logic [15:0] cfg_offset = '0;
    logic        idx_valid = 1'b0;
    logic        idx_ready;
    logic [15:0] idx_data = '0;
    logic        proc_req_valid;
    logic        proc_req_ready = 1'b0;
    logic [15:0] proc_req_index;
    logic        proc_rsp_valid = 1'b0;
    logic        proc_rsp_ready;
    logic [31:0] proc_rsp_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic [15:0] out_index;
    logic        out_hit;
    logic        done;
    logic        bad_index;

    vtx_index_cache uut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_indexed(cfg_indexed), .cfg_wide(cfg_wide),
        .cfg_count(cfg_count), .cfg_offset(cfg_offset),
        .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_data(idx_data),
        .proc_req_valid(proc_req_valid), .proc_req_ready(proc_req_ready),
        .proc_req_index(proc_req_index),
        .proc_rsp_valid(proc_rsp_valid), .proc_rsp_ready(proc_rsp_ready),
        .proc_rsp_data(proc_rsp_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_index(out_index), .out_hit(out_hit),
        .done(done), .bad_index(bad_index)
    );

    always #2 clk = ~clk;   // 250 MHz

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // monitors
    int bad_cnt = 0;
    int rdy_cnt = 0;
    int req_cnt = 0;
    int hit_cnt = 0;

    // stimulus list
    logic [15:0] lst [0:63];

    // reference model of the store
    logic [15:0] mt [0:DEPTH-1];
    logic [31:0] mp [0:DEPTH-1];
    int          mptr = 0;
    logic [15:0] serial_m = '0;
    bit          m_indexed;
    bit          m_wide;
    logic [15:0] m_offset;

    // processing unit model
    logic [15:0] serial_p = '0;
    bit          pend = 0;
    int          wait_c = 0;
    logic [15:0] pend_idx = '0;
    bit          req_fire = 0;
    bit          rsp_fire = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                summary();
                $finish;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (bad_index) bad_cnt++;
            if (idx_ready) rdy_cnt++;
        end
    end

    // processing unit: accepts every other cycle, answers after a delay
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                proc_rsp_valid = 1'b0;
                proc_req_ready = 1'b0;
                pend = 0; req_fire = 0; rsp_fire = 0;
            end else begin
                if (rsp_fire) begin
                    proc_rsp_valid = 1'b0;
                    rsp_fire = 0;
                end
                if (req_fire) begin
                    pend = 1;
                    wait_c = 2;
                    req_fire = 0;
                end
                if (pend && !proc_rsp_valid) begin
                    if (wait_c == 0) begin
                        proc_rsp_data  = {serial_p, pend_idx};
                        serial_p       = serial_p + 16'd1;
                        proc_rsp_valid = 1'b1;
                        pend = 0;
                    end else begin
                        wait_c--;
                    end
                end
                proc_req_ready = cyc[0];
                if (proc_req_valid && proc_req_ready) begin
                    pend_idx = proc_req_index;
                    req_fire = 1;
                    req_cnt++;
                end
                if (proc_rsp_valid && proc_rsp_ready) rsp_fire = 1;
            end
        end
    end

    task automatic feed(input int n);
        int k = 0;
        while (k < n) begin
            @(negedge clk);
            idx_valid = 1'b1;
            idx_data  = lst[k];
            if (idx_ready) k++;
        end
        @(negedge clk);
        idx_valid = 1'b0;
    endtask

    task automatic collect(input int n, input int pat);
        int k = 0;
        while (k < n) begin
            @(negedge clk);
            out_ready = (pat == 0) ? 1'b1 : ((cyc % pat) != 0);
            if (out_valid && out_ready) begin
                logic [15:0] ei;
                logic [31:0] ed;
                bit eh;
                int slot;
                if (m_indexed) ei = m_wide ? lst[k] : {8'h00, lst[k][7:0]};
                else           ei = 16'(k) + m_offset;
                slot = -1;
                if (m_indexed && ei != 16'hFFFF) begin
                    for (int s = 0; s < DEPTH; s++)
                        if (slot < 0 && mt[s] == ei) slot = s;
                end
                if (slot >= 0) begin
                    eh = 1; ed = mp[slot];
                end else begin
                    eh = 0; ed = {serial_m, ei};
                    serial_m = serial_m + 16'd1;
                    if (m_indexed && ei != 16'hFFFF) begin
                        mt[mptr] = ei; mp[mptr] = ed;
                        mptr = (mptr + 1) % DEPTH;
                    end
                end
                if (out_hit) hit_cnt++;
                chk(out_index == ei, "R9 order/index", out_index, ei);
                chk(out_hit == eh, "R2/R3 hit flag", out_hit, eh);
                chk(out_data == ed, "R2/R3 payload", out_data, ed);
                k++;
            end
        end
        @(negedge clk);
        out_ready = 1'b1;
    endtask

    task automatic run_draw(input bit ind, input bit wide, input int cnt,
                            input logic [15:0] off, input int pat, input bit poke);
        @(negedge clk);
        cfg_indexed = ind; cfg_wide = wide;
        cfg_count = 16'(cnt); cfg_offset = off;
        start = 1'b1;
        m_indexed = ind; m_wide = wide; m_offset = off;
        for (int s = 0; s < DEPTH; s++) mt[s] = 16'hFFFF;
        mptr = 0;
        @(negedge clk);
        start = 1'b0;
        if (cnt > 0) chk(done == 1'b0, "R10 done low while running", done, 0);
        fork
            begin if (ind) feed(cnt); end
            begin collect(cnt, pat); end
            begin
                if (poke) begin
                    repeat (6) @(negedge clk);
                    start = 1'b1; cfg_indexed = 1'b0; cfg_count = 16'd2;
                    @(negedge clk);
                    start = 1'b0;
                end
            end
        join
        chk(done == 1'b1, "R10 done after last output", done, 1);
    endtask

    task automatic t_reset();
        chk(out_valid == 0 && idx_ready == 0 && proc_req_valid == 0,
            "R1 handshakes low after reset", {out_valid, idx_ready, proc_req_valid}, 0);
        chk(done == 0 && bad_index == 0, "R1 status low after reset", {done, bad_index}, 0);
    endtask

    task automatic t_hits();
        int h0 = hit_cnt; int r0 = req_cnt;
        lst[0] = 16'd3; lst[1] = 16'd5; lst[2] = 16'd3; lst[3] = 16'd3;
        lst[4] = 16'd9; lst[5] = 16'd5; lst[6] = 16'h1234; lst[7] = 16'd9;
        run_draw(1, 1, 8, 16'd0, 3, 0);
        chk(hit_cnt - h0 == 4, "R2 hits in repeated indexes", hit_cnt - h0, 4);
        chk(req_cnt - r0 == 4, "R3 requests only on misses", req_cnt - r0, 4);
    endtask

    task automatic t_invalidate();
        int h0 = hit_cnt;
        lst[0] = 16'd3; lst[1] = 16'd3;
        run_draw(1, 1, 2, 16'd0, 0, 0);
        chk(hit_cnt - h0 == 1, "R5 first use after start misses", hit_cnt - h0, 1);
    endtask

    task automatic t_narrow();
        int h0 = hit_cnt;
        lst[0] = 16'hAB05; lst[1] = 16'h0005; lst[2] = 16'hFF07; lst[3] = 16'h1107;
        run_draw(1, 0, 4, 16'd0, 0, 0);
        chk(hit_cnt - h0 == 2, "R6 upper byte ignored in 8-bit mode", hit_cnt - h0, 2);
    endtask

    task automatic t_rr();
        int r0 = req_cnt;
        for (int i = 0; i < 33; i++) lst[i] = 16'(100 + i);
        lst[33] = 16'd100; lst[34] = 16'd102; lst[35] = 16'd101;
        run_draw(1, 1, 36, 16'd0, 0, 0);
        chk(req_cnt - r0 == 35, "R4 wrap evicts oldest slots", req_cnt - r0, 35);
    endtask

    task automatic t_bad();
        int b0 = bad_cnt; int h0 = hit_cnt;
        lst[0] = 16'hFFFF; lst[1] = 16'd4; lst[2] = 16'hFFFF; lst[3] = 16'd4;
        run_draw(1, 1, 4, 16'd0, 2, 0);
        chk(bad_cnt - b0 == 2, "R8 flag per all-ones index", bad_cnt - b0, 2);
        chk(hit_cnt - h0 == 1, "R8 all-ones never cached", hit_cnt - h0, 1);
    endtask

    task automatic t_nonidx();
        int b0 = bad_cnt; int r0 = rdy_cnt; int q0 = req_cnt; int h0 = hit_cnt;
        run_draw(0, 1, 5, 16'hFFFE, 0, 0);
        chk(rdy_cnt - r0 == 0, "R7 index stream untouched", rdy_cnt - r0, 0);
        chk(req_cnt - q0 == 5, "R7 every vertex processed", req_cnt - q0, 5);
        chk(hit_cnt - h0 == 0, "R7 no hits in bypass", hit_cnt - h0, 0);
        chk(bad_cnt - b0 == 1, "R8 flag in bypass mode", bad_cnt - b0, 1);
    endtask

    task automatic t_zero();
        int q0 = req_cnt;
        run_draw(0, 0, 0, 16'd0, 0, 0);
        repeat (3) @(negedge clk);
        chk(done == 1 && out_valid == 0, "R10 zero count finishes silently",
            {done, out_valid}, 2'b10);
        chk(req_cnt == q0, "R10 zero count no request", req_cnt - q0, 0);
    endtask

    task automatic t_restart_ignored();
        int q0 = req_cnt;
        for (int i = 0; i < 6; i++) lst[i] = 16'(i % 2 + 20);
        run_draw(1, 1, 6, 16'd0, 2, 1);
        chk(req_cnt - q0 == 2, "R11 running draw keeps its settings", req_cnt - q0, 2);
        repeat (4) @(negedge clk);
        chk(done == 1, "R11 no second draw launched", done, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        out_ready = 1'b1;
        t_hits();
        t_invalidate();
        t_narrow();
        t_rr();
        t_bad();
        t_nonidx();
        t_zero();
        t_restart_ignored();
        summary();
        $finish;
    end

endmodule